// File: doc/BRIEF.md
# Octal DAC Command Register Decoder

This block sits behind a serial receiver that has already gathered complete 16-bit command words. Each word arrives with a one-cycle valid strobe. The block keeps eight staged sample registers and eight live converter registers. It drives the live values, the reference-source, buffering and gain settings for the two channel groups, and a load strobe made by the selected load policy.

The top bit of a word says what kind of word it is. A data word stores a 12-bit sample into the staging register of one channel. A control word does one of four things: sets reference and gain, picks the load policy, records a raw power-down field, or clears the whole block to its defaults. The load policy decides how staged samples reach the live registers. They can flow straight through, be held back, or be copied across all channels at once by a single one-shot pulse.

Top module: `octal_dac_cmd_dec`

## Requirements
- R1: When `word_valid` is high and bit 15 is 0, bits 14:12 select the channel (0 to 7, where 0 is the first channel) and bits 11:0 are written into that channel's staging register. The new value shows on `inreg_out` after the accepting clock edge.
- R2: When bit 15 is 1, bits 14:13 select the control function: 00 reference/gain, 01 load policy, 10 power-down, 11 clear.
- R3: A reference/gain word latches bit 0 (first group, channels 0-3) and bit 1 (second group, channels 4-7) into `ref_rail`. It latches bits 2 and 3 into `ref_buffered` and bits 4 and 5 into `gain_x2`, for the same two groups.
- R4: When a group's rail-reference bit is set, that group's `ref_buffered` and `gain_x2` read 0, whatever bits 2 to 5 hold.
- R5: With load policy 00 (`load_mode` = 00), a data write reaches `dac_out` on the same edge that updates `inreg_out`. On entry to policy 00, all live registers take the staged values on the following edge.
- R6: With load policy 01 (`load_mode` = 01), data writes change `inreg_out` and leave `dac_out` unchanged.
- R7: Load bits 10 raise `load_strobe` for exactly one cycle after the accepting edge. The next edge copies every staging register into its live register. `load_mode` reads 01 from then on.
- R8: Load bits 11 change nothing.
- R9: After `rst`, all registers and `pd_field` read 0, `load_mode` reads 01 and `load_strobe` reads 0.
- R10: A clear word (control function 11) zeroes all staging and live registers and `pd_field`. It returns the reference, buffering and gain outputs to 0 and `load_mode` to 01, on the accepting edge.
- R11: A power-down word stores bits 12:0 in `pd_field` and leaves all channel registers unchanged.
- R12: When `word_valid` is low, `word_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Qualifies `word_in` for one cycle |
| word_in | input | 16 | Complete command word |
| inreg_out | output | 96 | Staging registers, channel c at bits c*12 +: 12 |
| dac_out | output | 96 | Live converter registers, same packing |
| ref_rail | output | 2 | Per group: reference taken from the supply rail |
| ref_buffered | output | 2 | Per group: reference buffer enabled |
| gain_x2 | output | 2 | Per group: output span doubled |
| load_mode | output | 2 | Active load policy (00 flow, 01 hold) |
| load_strobe | output | 1 | One-cycle internal update pulse |
| pd_field | output | 13 | Raw power-down field last written |

## Verification
A corrupted load policy shows up as live values that either track staged writes when they should hold, or fail to follow them. This is visible on `dac_out` one edge after the offending data word. A stuck or repeated update pulse shows on `load_strobe` in the cycle after the single-update word, and on the live values one edge later. Errors in group decoding appear on the reference and gain outputs on the edge that accepts the word. A clear that misses a register leaves a nonzero value on the packed outputs right after the clear.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int WORD_W  = 16;
  localparam int DATA_W  = 12;
  localparam int NUM_CH  = 8;
  localparam int CH_AW   = $clog2(NUM_CH);
  localparam int NUM_GRP = 2;
  localparam int PD_W    = 13;

  typedef enum logic [1:0] {
    CF_REFGAIN = 2'b00,
    CF_LOAD    = 2'b01,
    CF_PWRDN   = 2'b10,
    CF_CLEAR   = 2'b11
  } ctrl_fn_e;

  typedef enum logic [1:0] {
    LM_FLOW   = 2'b00,
    LM_HOLD   = 2'b01,
    LM_SINGLE = 2'b10,
    LM_RSVD   = 2'b11
  } load_sel_e;

  typedef struct packed {
    logic              data_wr;
    logic [CH_AW-1:0]  ch;
    logic [DATA_W-1:0] sample;
    logic              refgain_wr;
    logic              load_wr;
    logic              pd_wr;
    logic              clr;
    logic [WORD_W-1:0] raw;
  } cmd_t;
endpackage

// File: rtl/octdac_cmd_decode.sv
module octdac_cmd_decode
  import octdac_pkg::*;
(
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output cmd_t              cmd
);
  logic     is_ctrl;
  ctrl_fn_e fn;

  always_comb begin
    is_ctrl        = word[WORD_W-1];
    fn             = ctrl_fn_e'(word[WORD_W-2 -: 2]);
    cmd            = '0;
    cmd.raw        = word;
    cmd.ch         = word[WORD_W-2 -: CH_AW];
    cmd.sample     = word[DATA_W-1:0];
    cmd.data_wr    = valid && !is_ctrl;                       // R1
    cmd.refgain_wr = valid && is_ctrl && (fn == CF_REFGAIN);  // R2
    cmd.load_wr    = valid && is_ctrl && (fn == CF_LOAD);
    cmd.pd_wr      = valid && is_ctrl && (fn == CF_PWRDN);
    cmd.clr        = valid && is_ctrl && (fn == CF_CLEAR);
  end
endmodule

// File: rtl/octdac_cfg_regs.sv
module octdac_cfg_regs
  import octdac_pkg::*;
#(
  parameter int N_GRP = NUM_GRP
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_t             cmd,
  output logic [N_GRP-1:0] rail_q,
  output logic [N_GRP-1:0] buf_q,
  output logic [N_GRP-1:0] gain_q,
  output load_sel_e        mode_q,
  output logic             strobe_q,
  output logic [PD_W-1:0]  pd_q
);
  localparam int BUF_LSB  = N_GRP;
  localparam int GAIN_LSB = 2 * N_GRP;

  always_ff @(posedge clk) begin
    if (rst || cmd.clr) begin
      rail_q   <= '0;
      buf_q    <= '0;
      gain_q   <= '0;
      mode_q   <= LM_HOLD;
      strobe_q <= 1'b0;
      pd_q     <= '0;
    end else begin
      strobe_q <= 1'b0;
      if (cmd.refgain_wr) begin
        for (int g = 0; g < N_GRP; g++) begin
          rail_q[g] <= cmd.raw[g];
          buf_q[g]  <= cmd.raw[BUF_LSB + g]  & ~cmd.raw[g];
          gain_q[g] <= cmd.raw[GAIN_LSB + g] & ~cmd.raw[g];
        end
      end
      if (cmd.load_wr) begin
        case (load_sel_e'(cmd.raw[1:0]))
          LM_FLOW:   mode_q <= LM_FLOW;
          LM_HOLD:   mode_q <= LM_HOLD;
          LM_SINGLE: begin
            mode_q   <= LM_HOLD;
            strobe_q <= 1'b1;
          end
          default: ;
        endcase
      end
      if (cmd.pd_wr) pd_q <= cmd.raw[PD_W-1:0];
    end
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q); // R7
  AST_SINGLE_FALLS_BACK: assert property (@(posedge clk) disable iff (rst)
    (cmd.load_wr && cmd.raw[1:0] == 2'b10) |=> (strobe_q && mode_q == LM_HOLD)); // R7
  AST_RSVD_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (cmd.load_wr && cmd.raw[1:0] == 2'b11) |=> ($stable(mode_q) && !strobe_q)); // R8
  AST_RAIL_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    (cmd.refgain_wr && cmd.raw[0]) |=> (rail_q[0] && !buf_q[0] && !gain_q[0])); // R4
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LM_FLOW) || (mode_q == LM_HOLD)); // R7
endmodule

// File: rtl/octdac_chan_regs.sv
module octdac_chan_regs
  import octdac_pkg::*;
#(
  parameter int N_CH  = NUM_CH,
  parameter int DW    = DATA_W,
  parameter int AW    = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_ch,
  input  logic [DW-1:0]    wr_data,
  input  load_sel_e        mode,
  input  logic             strobe,
  output logic [N_CH*DW-1:0] in_flat,
  output logic [N_CH*DW-1:0] dac_flat
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [DW-1:0] in_q;
    logic [DW-1:0] dac_q;
    logic [DW-1:0] in_nx;

    always_comb in_nx = (wr_en && wr_ch == AW'(i)) ? wr_data : in_q;

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        in_q  <= '0;
        dac_q <= '0;
      end else begin
        in_q <= in_nx;
        if (mode == LM_FLOW) dac_q <= in_nx;
        else if (strobe)     dac_q <= in_q;
      end
    end

    assign in_flat[i*DW +: DW]  = in_q;
    assign dac_flat[i*DW +: DW] = dac_q;
  end

  AST_HOLD_KEEPS_DAC: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_HOLD && !strobe && !clr) |=> $stable(dac_flat)); // R6
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dac_flat == '0 && in_flat == '0)); // R10
  AST_FLOW_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_FLOW && !clr) |=> (dac_flat == in_flat)); // R5
endmodule

// File: rtl/octal_dac_cmd_dec.sv
module octal_dac_cmd_dec
  import octdac_pkg::*;
#(
  parameter int N_CH  = NUM_CH,
  parameter int DW    = DATA_W,
  parameter int N_GRP = NUM_GRP
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 word_valid,
  input  logic [WORD_W-1:0]    word_in,
  output logic [N_CH*DW-1:0]   inreg_out,
  output logic [N_CH*DW-1:0]   dac_out,
  output logic [N_GRP-1:0]     ref_rail,
  output logic [N_GRP-1:0]     ref_buffered,
  output logic [N_GRP-1:0]     gain_x2,
  output logic [1:0]           load_mode,
  output logic                 load_strobe,
  output logic [PD_W-1:0]      pd_field
);
  localparam int AW = $clog2(N_CH);

  cmd_t      cmd;
  load_sel_e mode_q;

  octdac_cmd_decode u_dec (
    .valid (word_valid),
    .word  (word_in),
    .cmd   (cmd)
  );

  octdac_cfg_regs #(.N_GRP(N_GRP)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .rail_q   (ref_rail),
    .buf_q    (ref_buffered),
    .gain_q   (gain_x2),
    .mode_q   (mode_q),
    .strobe_q (load_strobe),
    .pd_q     (pd_field)
  );

  octdac_chan_regs #(.N_CH(N_CH), .DW(DW), .AW(AW)) u_ch (
    .clk      (clk),
    .rst      (rst),
    .clr      (cmd.clr),
    .wr_en    (cmd.data_wr),
    .wr_ch    (cmd.ch[AW-1:0]),
    .wr_data  (cmd.sample[DW-1:0]),
    .mode     (mode_q),
    .strobe   (load_strobe),
    .in_flat  (inreg_out),
    .dac_flat (dac_out)
  );

  assign load_mode = mode_q;

  AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (!word_valid && mode_q == LM_HOLD && !load_strobe) |=> ($stable(inreg_out) && $stable(dac_out))); // R12
  AST_PD_KEEPS_CH: assert property (@(posedge clk) disable iff (rst)
    (cmd.pd_wr && mode_q == LM_HOLD && !load_strobe) |=> ($stable(inreg_out) && $stable(dac_out))); // R11
endmodule

// File: tb/tb_octal_dac_cmd_dec.sv
module tb_octal_dac_cmd_dec;
  localparam int NCH = 8;
  localparam int DW  = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              word_valid = 1'b0;
  logic [15:0]       word_in = '0;
  logic [NCH*DW-1:0] inreg_out, dac_out;
  logic [1:0]        ref_rail, ref_buffered, gain_x2, load_mode;
  logic              load_strobe;
  logic [12:0]       pd_field;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_in [NCH];
  logic [DW-1:0] m_dac[NCH];
  logic [1:0]    m_mode;

  always #5 clk = ~clk;

  octal_dac_cmd_dec dut (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
    .inreg_out(inreg_out), .dac_out(dac_out), .ref_rail(ref_rail),
    .ref_buffered(ref_buffered), .gain_x2(gain_x2), .load_mode(load_mode),
    .load_strobe(load_strobe), .pd_field(pd_field)
  );

  // {word, channel, expected staging, expected live, expected policy}
  localparam logic [44:0] VEC [0:10] = '{
    {16'h0123, 3'd0, 12'h123, 12'h000, 2'b01},  // R1 R6
    {16'h7ABC, 3'd7, 12'hABC, 12'h000, 2'b01},  // R1 R6
    {16'hA002, 3'd7, 12'hABC, 12'hABC, 2'b01},  // R7
    {16'h7111, 3'd7, 12'h111, 12'hABC, 2'b01},  // R6
    {16'hA003, 3'd7, 12'h111, 12'hABC, 2'b01},  // R8
    {16'hA000, 3'd7, 12'h111, 12'h111, 2'b00},  // R5
    {16'h3555, 3'd3, 12'h555, 12'h555, 2'b00},  // R5
    {16'hA001, 3'd3, 12'h555, 12'h555, 2'b01},  // R2
    {16'h3666, 3'd3, 12'h666, 12'h555, 2'b01},  // R6
    {16'hC0AB, 3'd3, 12'h666, 12'h555, 2'b01},  // R11
    {16'hE000, 3'd3, 12'h000, 12'h000, 2'b01}   // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ch_in(input int c);
    return inreg_out[c*DW +: DW];
  endfunction

  function automatic logic [DW-1:0] ch_dac(input int c);
    return dac_out[c*DW +: DW];
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin m_in[c] = '0; m_dac[c] = '0; end
    m_mode = 2'b01;
  endtask

  // Drives one word for one edge, updates the model, then waits one settling edge.
  task automatic apply_word(input logic [15:0] w);
    @(negedge clk);
    word_in = w; word_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    word_valid = 1'b0;
    if (!w[15]) begin
      m_in[w[14:12]] = w[11:0];
      if (m_mode == 2'b00) m_dac[w[14:12]] = w[11:0];
    end else if (w[14:13] == 2'b01) begin
      if (w[1:0] == 2'b00) begin
        m_mode = 2'b00;
        for (int c = 0; c < NCH; c++) m_dac[c] = m_in[c];
      end else if (w[1:0] == 2'b01) m_mode = 2'b01;
      else if (w[1:0] == 2'b10) begin
        m_mode = 2'b01;
        for (int c = 0; c < NCH; c++) m_dac[c] = m_in[c];
      end
    end else if (w[14:13] == 2'b11) model_reset();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [44:0] v;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 staging", 32'(inreg_out == '0), 1);
    chk("R9 live", 32'(dac_out == '0), 1);
    chk("R9 policy", 32'(load_mode), 32'h1);
    chk("R9 strobe", 32'(load_strobe), 0);
    chk("R9 pd", 32'(pd_field), 0);
    chk("R9 ref", 32'({ref_rail, ref_buffered, gain_x2}), 0);

    for (int k = 0; k < 11; k++) begin
      v = VEC[k];
      apply_word(v[44:29]);
      chk("R1 table staging", 32'(ch_in(int'(v[28:26]))), 32'(v[25:14]));
      chk("R6 table live", 32'(ch_dac(int'(v[28:26]))), 32'(v[13:2]));
      chk("R2 table policy", 32'(load_mode), 32'(v[1:0]));
      for (int c = 0; c < NCH; c++) begin
        chk("R5 model staging", 32'(ch_in(c)), 32'(m_in[c]));
        chk("R7 model live", 32'(ch_dac(c)), 32'(m_dac[c]));
      end
    end

    // R12 idle bus ignored
    @(negedge clk); word_in = 16'h0FFF; word_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 idle staging", 32'(ch_in(0)), 0);

    // R3 reference and gain
    apply_word(16'h803C);
    chk("R3 rail", 32'(ref_rail), 0);
    chk("R3 buf", 32'(ref_buffered), 32'h3);
    chk("R3 gain", 32'(gain_x2), 32'h3);
    // R4 rail override on first group only
    apply_word(16'h803D);
    chk("R4 rail", 32'(ref_rail), 32'h1);
    chk("R4 buf", 32'(ref_buffered), 32'h2);
    chk("R4 gain", 32'(gain_x2), 32'h2);

    // R7 one-shot strobe timing
    apply_word(16'h5222);
    @(negedge clk);
    word_in = 16'hA002; word_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    word_valid = 1'b0;
    chk("R7 strobe high", 32'(load_strobe), 1);
    chk("R7 live not yet", 32'(ch_dac(5)), 0);
    @(posedge clk); @(negedge clk);
    chk("R7 strobe low", 32'(load_strobe), 0);
    chk("R7 live copied", 32'(ch_dac(5)), 32'h222);
    // R7 single update from flow policy falls back to hold
    apply_word(16'hA000);
    apply_word(16'hA002);
    chk("R7 fallback", 32'(load_mode), 32'h1);
    apply_word(16'h5333);
    chk("R6 held", 32'(ch_dac(5)), 32'h222);

    // R11 power-down field
    apply_word(16'hC0AB);
    chk("R11 pd", 32'(pd_field), 32'h0AB);
    chk("R11 staging", 32'(ch_in(5)), 32'h333);
    chk("R11 live", 32'(ch_dac(5)), 32'h222);

    // R10 clear word
    apply_word(16'hA000);
    apply_word(16'hE000);
    chk("R10 pd", 32'(pd_field), 0);
    chk("R10 ref", 32'({ref_rail, ref_buffered, gain_x2}), 0);
    chk("R10 policy", 32'(load_mode), 32'h1);
    chk("R10 regs", 32'(inreg_out == '0 && dac_out == '0), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule